// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block drives an RGB panel from a single pixel clock. A line counter and a frame counter run together. The horizontal coordinate counts pixel clocks within a line. The vertical coordinate is not a line number: it is the absolute number of pixel clocks since the start of the frame. Every vertical limit (frame period, vsync width, display start and end, active start and end) is therefore programmed as a pixel-clock count. A line count becomes such a count when multiplied by the line period, and the hsync skew is added to the display limits.

A word-addressed write port loads the configuration. From it the block generates hsync, vsync and data enable, each with selectable polarity. It asks an upstream source for a pixel (`pix_req`) in every cycle that lies inside the active window. The active window is the display window, optionally narrowed by an inner horizontal and vertical window. Display pixels outside the active window show the border colour. When the source fails to supply a requested pixel, the block shows an underflow colour and raises a sticky flag. That flag either holds until the block is disabled or clears on its own at the next frame boundary.

A small controller has three states. OFF means the counters are held at zero and the outputs are idle. RUN is normal scanning. UFLOW means the source has underflowed. The transitions are:
- enable-set: OFF to RUN.
- starve: RUN to UFLOW, when a requested pixel is not valid.
- recover: UFLOW to RUN, on the frame-wrap edge when recovery is enabled.
- disable: RUN or UFLOW to OFF, when the enable bit is cleared.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the block is disabled. hsync, vsync, de, pix_req, underflow and rgb_out are all 0, because all polarity bits reset to 0.
- R2: Writing 1 to bit 0 of word 0 enables the block. One cycle after the enable bit is stored, the counters begin at line position 0 and frame position 0. Writing 0 to that bit forces every output to its idle level from the next cycle on, with the counters at zero.
- R3: Word 1 holds the line period in bits 31:16 and the hsync width in bits 15:0. hsync is active while the line position x is less than the width. x counts 0 up to period-1, then wraps.
- R4: Word 2 holds the frame period in pixel clocks and word 12 holds the hsync skew. The frame position f counts 0 up to period-1, then wraps. vsync is active for skew <= f < skew + width, where word 3 holds the width in pixel clocks.
- R5: Word 4 holds the last displayed x in bits 31:16 and the first displayed x in bits 15:0. Words 5 and 6 hold the first and last displayed f. de is active when x and f lie inside these inclusive bounds.
- R6: Word 7 sets the inner x window, with its end in bits 31:16 and its start in bits 15:0. A value of zero turns this window off. Word 8 holds the inner f start in its low bits and an enable flag in bit 31. Word 9 holds the inner f end. pix_req is high exactly on display pixels that lie inside every enabled inner window.
- R7: rgb_out is 0 outside the display window. It is the border colour (word 10) on display pixels outside the active window. It is pix_data on active pixels while the pixel source is valid and there is no underflow.
- R8: A cycle with pix_req high and pix_valid low shows the underflow colour (word 11, low bits) in that cycle. underflow rises on the next cycle. From then on every active pixel shows the underflow colour. With bit 31 of word 11 clear, the flag holds until the block is disabled.
- R9: With bit 31 of word 11 set, the underflow flag clears on the edge where f wraps to 0. This recovery wins over a new starve that falls in that same last cycle of the frame.
- R10: In word 14, bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de. The inversion also applies to the idle levels.
- R11: A register is written when wr_en is high at a clock edge. wr_addr is the byte offset divided by four. The new value takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| pix_data | input | C_W | Pixel from upstream source |
| pix_valid | input | 1 | Upstream pixel valid |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable over the display window, polarity applied |
| pix_req | output | 1 | Pixel request during active pixels |
| rgb_out | output | C_W | Pixel bus to panel |
| underflow | output | 1 | Sticky underflow flag |

## Verification
Two functions can meet in one cycle: starve detection and the frame-wrap recovery. They meet when a requested pixel is missing in the very last pixel clock of the frame. The bench sets up this case by programming zero front porches, so the display window reaches f = period-1. It then withholds pix_valid at exactly that position, first while in RUN and again one frame later while in UFLOW with recovery on. The first starve must take the block into UFLOW across the wrap. The second must lose to recovery, so the flag reads 0 at f = 0. The bench judges this both through its cycle-by-cycle reference prediction and through directed reads of the flag.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int REG_W   = 32;
    localparam int WADDR_W = 4;
    localparam int HI_LSB  = 16;   // upper packed field starts here
    localparam int FLAG_BIT = 31;  // enable / recovery flags

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_UFLOW = 2'd2
    } tg_state_e;

    // word addresses (byte offset / 4); software relies on these
    localparam logic [WADDR_W-1:0] A_ENABLE  = 4'd0;
    localparam logic [WADDR_W-1:0] A_HSYNC   = 4'd1;
    localparam logic [WADDR_W-1:0] A_VPERIOD = 4'd2;
    localparam logic [WADDR_W-1:0] A_VPULSE  = 4'd3;
    localparam logic [WADDR_W-1:0] A_HDISP   = 4'd4;
    localparam logic [WADDR_W-1:0] A_VDSTART = 4'd5;
    localparam logic [WADDR_W-1:0] A_VDEND   = 4'd6;
    localparam logic [WADDR_W-1:0] A_HACT    = 4'd7;
    localparam logic [WADDR_W-1:0] A_VASTART = 4'd8;
    localparam logic [WADDR_W-1:0] A_VAEND   = 4'd9;
    localparam logic [WADDR_W-1:0] A_BORDER  = 4'd10;
    localparam logic [WADDR_W-1:0] A_UFCOL   = 4'd11;
    localparam logic [WADDR_W-1:0] A_SKEW    = 4'd12;
    localparam logic [WADDR_W-1:0] A_POL     = 4'd14;

endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
#(
    parameter int X_W = 16,
    parameter int F_W = 24,
    parameter int C_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic               en,
    output logic [X_W-1:0]     hper,
    output logic [X_W-1:0]     hsw,
    output logic [X_W-1:0]     hfirst,
    output logic [X_W-1:0]     hlast,
    output logic               ha_en,
    output logic [X_W-1:0]     ha_first,
    output logic [X_W-1:0]     ha_last,
    output logic [F_W-1:0]     vper,
    output logic [F_W-1:0]     vsw,
    output logic [F_W-1:0]     vstart,
    output logic [F_W-1:0]     vend,
    output logic               va_en,
    output logic [F_W-1:0]     va_first,
    output logic [F_W-1:0]     va_last,
    output logic [F_W-1:0]     skew,
    output logic [C_W-1:0]     border,
    output logic [C_W-1:0]     ufcol,
    output logic               uf_rec,
    output logic [2:0]         pol
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            hper     <= '0;
            hsw      <= '0;
            hfirst   <= '0;
            hlast    <= '0;
            ha_en    <= 1'b0;
            ha_first <= '0;
            ha_last  <= '0;
            vper     <= '0;
            vsw      <= '0;
            vstart   <= '0;
            vend     <= '0;
            va_en    <= 1'b0;
            va_first <= '0;
            va_last  <= '0;
            skew     <= '0;
            border   <= '0;
            ufcol    <= '0;
            uf_rec   <= 1'b0;
            pol      <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ENABLE:  en <= wr_data[0];
                A_HSYNC: begin
                    hper <= wr_data[HI_LSB +: X_W];
                    hsw  <= wr_data[X_W-1:0];
                end
                A_VPERIOD: vper <= wr_data[F_W-1:0];
                A_VPULSE:  vsw  <= wr_data[F_W-1:0];
                A_HDISP: begin
                    hlast  <= wr_data[HI_LSB +: X_W];
                    hfirst <= wr_data[X_W-1:0];
                end
                A_VDSTART: vstart <= wr_data[F_W-1:0];
                A_VDEND:   vend   <= wr_data[F_W-1:0];
                A_HACT: begin
                    ha_last  <= wr_data[HI_LSB +: X_W];
                    ha_first <= wr_data[X_W-1:0];
                    ha_en    <= |wr_data;
                end
                A_VASTART: begin
                    va_en    <= wr_data[FLAG_BIT];
                    va_first <= wr_data[F_W-1:0];
                end
                A_VAEND:   va_last <= wr_data[F_W-1:0];
                A_BORDER:  border  <= wr_data[C_W-1:0];
                A_UFCOL: begin
                    uf_rec <= wr_data[FLAG_BIT];
                    ufcol  <= wr_data[C_W-1:0];
                end
                A_SKEW:    skew <= wr_data[F_W-1:0];
                A_POL:     pol  <= wr_data[2:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter #(
    parameter int X_W = 16,
    parameter int F_W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [X_W-1:0] hper,
    input  logic [F_W-1:0] vper,
    output logic [X_W-1:0] hpos,
    output logic [F_W-1:0] fpos,
    output logic           f_last
);

    logic h_last;

    assign h_last = (hpos == hper - 1'b1);
    assign f_last = (fpos == vper - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpos <= '0;
            fpos <= '0;
        end else if (!run) begin
            hpos <= '0;
            fpos <= '0;
        end else begin
            hpos <= h_last ? '0 : hpos + 1'b1;
            fpos <= f_last ? '0 : fpos + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
    parameter int X_W = 16,
    parameter int F_W = 24
) (
    input  logic           run,
    input  logic [X_W-1:0] hpos,
    input  logic [F_W-1:0] fpos,
    input  logic [X_W-1:0] hsw,
    input  logic [X_W-1:0] hfirst,
    input  logic [X_W-1:0] hlast,
    input  logic           ha_en,
    input  logic [X_W-1:0] ha_first,
    input  logic [X_W-1:0] ha_last,
    input  logic [F_W-1:0] vsw,
    input  logic [F_W-1:0] vstart,
    input  logic [F_W-1:0] vend,
    input  logic           va_en,
    input  logic [F_W-1:0] va_first,
    input  logic [F_W-1:0] va_last,
    input  logic [F_W-1:0] skew,
    output logic           hs_act,
    output logic           vs_act,
    output logic           disp,
    output logic           act
);

    logic [F_W:0] vs_stop;
    logic         h_in, f_in, ha_in, va_in;

    always_comb begin
        vs_stop = {1'b0, skew} + {1'b0, vsw};
        hs_act  = run && (hpos < hsw);
        vs_act  = run && (fpos >= skew) && ({1'b0, fpos} < vs_stop);
        h_in    = (hpos >= hfirst) && (hpos <= hlast);
        f_in    = (fpos >= vstart) && (fpos <= vend);
        ha_in   = !ha_en || ((hpos >= ha_first) && (hpos <= ha_last));
        va_in   = !va_en || ((fpos >= va_first) && (fpos <= va_last));
        disp    = run && h_in && f_in;
        act     = disp && ha_in && va_in;
    end

endmodule

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
    import lcd_tg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      starve,
    input  logic      frame_last,
    input  logic      uf_rec,
    output tg_state_e state,
    output logic      run,
    output logic      uf_flag
);

    tg_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (en) nxt = ST_RUN;
            ST_RUN: begin
                if (!en)         nxt = ST_OFF;
                else if (starve) nxt = ST_UFLOW;
            end
            ST_UFLOW: begin
                if (!en)                       nxt = ST_OFF;
                else if (uf_rec && frame_last) nxt = ST_RUN;
            end
            default:  nxt = ST_OFF;
        endcase
    end

    always_comb begin
        run     = en && (state != ST_OFF);
        uf_flag = en && (state == ST_UFLOW);
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int X_W = 16,
    parameter int F_W = 24,
    parameter int C_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [C_W-1:0]     pix_data,
    input  logic               pix_valid,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               pix_req,
    output logic [C_W-1:0]     rgb_out,
    output logic               underflow
);

    logic           en, ha_en, va_en, uf_rec;
    logic [X_W-1:0] hper, hsw, hfirst, hlast, ha_first, ha_last;
    logic [F_W-1:0] vper, vsw, vstart, vend, va_first, va_last, skew;
    logic [C_W-1:0] border, ufcol;
    logic [2:0]     pol;
    logic [X_W-1:0] hpos;
    logic [F_W-1:0] fpos;
    logic           f_last, frame_last, starve, run, uf_flag;
    logic           hs_act, vs_act, disp, act;
    tg_state_e      state;

    lcd_tg_regs #(.X_W(X_W), .F_W(F_W), .C_W(C_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en(en), .hper(hper), .hsw(hsw),
        .hfirst(hfirst), .hlast(hlast), .ha_en(ha_en),
        .ha_first(ha_first), .ha_last(ha_last), .vper(vper), .vsw(vsw),
        .vstart(vstart), .vend(vend), .va_en(va_en), .va_first(va_first),
        .va_last(va_last), .skew(skew), .border(border), .ufcol(ufcol),
        .uf_rec(uf_rec), .pol(pol)
    );

    lcd_tg_counter #(.X_W(X_W), .F_W(F_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .hper(hper), .vper(vper),
        .hpos(hpos), .fpos(fpos), .f_last(f_last)
    );

    lcd_tg_window #(.X_W(X_W), .F_W(F_W)) u_win (
        .run(run), .hpos(hpos), .fpos(fpos), .hsw(hsw), .hfirst(hfirst),
        .hlast(hlast), .ha_en(ha_en), .ha_first(ha_first),
        .ha_last(ha_last), .vsw(vsw), .vstart(vstart), .vend(vend),
        .va_en(va_en), .va_first(va_first), .va_last(va_last),
        .skew(skew), .hs_act(hs_act), .vs_act(vs_act), .disp(disp),
        .act(act)
    );

    assign frame_last = run && f_last;
    assign starve     = act && !pix_valid;

    lcd_tg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .starve(starve),
        .frame_last(frame_last), .uf_rec(uf_rec), .state(state),
        .run(run), .uf_flag(uf_flag)
    );

    always_comb begin
        hsync     = hs_act ^ pol[0];
        vsync     = vs_act ^ pol[1];
        de        = disp ^ pol[2];
        pix_req   = act;
        underflow = uf_flag;
        if (!disp)                   rgb_out = '0;
        else if (!act)               rgb_out = border;
        else if (uf_flag || !pix_valid) rgb_out = ufcol;
        else                         rgb_out = pix_data;
    end

endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk
    import lcd_tg_pkg::*;
#(
    parameter int X_W = 16,
    parameter int C_W = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           run,
    input tg_state_e      state,
    input logic [X_W-1:0] hpos,
    input logic [X_W-1:0] hper,
    input logic           pix_req,
    input logic           pix_valid,
    input logic           underflow,
    input logic [C_W-1:0] rgb_out,
    input logic           hsync,
    input logic           vsync,
    input logic [2:0]     pol,
    input logic           uf_rec
);

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pix_req && rgb_out == '0 && !underflow));

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && en) |=> (hpos == '0));

    assert_line_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hpos != hper - 1'b1) |=> (hpos == X_W'($past(hpos) + 1'b1)));

    assert_starve_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_valid && state == ST_RUN) |=> (underflow || !run));

    assert_uf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UFLOW && en && !uf_rec) |=> (state == ST_UFLOW));

    assert_idle_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hsync == pol[0] && vsync == pol[1]));

endmodule

bind lcd_timing_gen lcd_tg_chk #(.X_W(X_W), .C_W(C_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .state(state),
    .hpos(hpos), .hper(hper), .pix_req(pix_req), .pix_valid(pix_valid),
    .underflow(underflow), .rgb_out(rgb_out), .hsync(hsync),
    .vsync(vsync), .pol(pol), .uf_rec(uf_rec)
);

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;

    localparam int C_W = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [3:0]    wr_addr;
    logic [31:0]   wr_data;
    logic [C_W-1:0] pix_data;
    logic          pix_valid;
    logic          hsync, vsync, de, pix_req, underflow;
    logic [C_W-1:0] rgb_out;

    always #10 clk = ~clk;

    lcd_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_data(pix_data), .pix_valid(pix_valid),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
        .rgb_out(rgb_out), .underflow(underflow)
    );

    typedef struct packed {
        logic           hs;
        logic           vs;
        logic           de;
        logic           req;
        logic [C_W-1:0] rgb;
        logic           uf;
    } exp_t;

    exp_t sbq[$];
    event ev_mon;
    int   n_chk = 0;
    int   n_err = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    // stimulus
    logic        d_wr = 1'b0;
    logic [3:0]  d_addr = '0;
    logic [31:0] d_data = '0;
    int          drop_f = -1;

    // reference model state
    int          m_st = 0;
    logic        m_en = 0, m_hae = 0, m_vae = 0, m_rec = 0;
    logic [15:0] m_h = 0, m_hper = 0, m_hsw = 0, m_hf = 0, m_hl = 0, m_haf = 0, m_hal = 0;
    logic [23:0] m_f = 0, m_vper = 0, m_vsw = 0, m_vst = 0, m_vend = 0, m_vaf = 0, m_val = 0, m_skew = 0;
    logic [23:0] m_bor = 0, m_ufc = 0;
    logic [2:0]  m_pol = 0;

    task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic tick();
        logic run, hs, vs, disp, hw, vw, act, flast;
        logic [24:0] vse;
        exp_t e;
        @(negedge clk);
        wr_en     = d_wr;
        wr_addr   = d_addr;
        wr_data   = d_data;
        pix_valid = !(drop_f >= 0 && int'(m_f) == drop_f);
        pix_data  = C_W'(32'h3C0000 + cyc * 7);
        #1;
        run  = (m_st != 0) && m_en;
        hs   = run && (m_h < m_hsw);
        vse  = {1'b0, m_skew} + {1'b0, m_vsw};
        vs   = run && (m_f >= m_skew) && ({1'b0, m_f} < vse);
        disp = run && m_h >= m_hf && m_h <= m_hl && m_f >= m_vst && m_f <= m_vend;
        hw   = !m_hae || (m_h >= m_haf && m_h <= m_hal);
        vw   = !m_vae || (m_f >= m_vaf && m_f <= m_val);
        act  = disp && hw && vw;
        e.hs  = hs ^ m_pol[0];
        e.vs  = vs ^ m_pol[1];
        e.de  = disp ^ m_pol[2];
        e.req = act;
        e.uf  = run && (m_st == 2);
        if (!disp)                      e.rgb = '0;
        else if (!act)                  e.rgb = m_bor;
        else if (m_st == 2 || !pix_valid) e.rgb = m_ufc;
        else                            e.rgb = pix_data;
        sbq.push_back(e);
        ->ev_mon;
        flast = (m_f == m_vper - 1'b1);
        if (!m_en) begin
            m_st = 0; m_h = '0; m_f = '0;
        end else if (m_st == 0) begin
            m_st = 1; m_h = '0; m_f = '0;
        end else begin
            if (m_st == 1 && act && !pix_valid)  m_st = 2;
            else if (m_st == 2 && m_rec && flast) m_st = 1;
            m_h = (m_h == m_hper - 1'b1) ? '0 : m_h + 1'b1;
            m_f = flast ? '0 : m_f + 1'b1;
        end
        if (d_wr) begin
            case (d_addr)
                4'd0:  m_en = d_data[0];
                4'd1:  begin m_hper = d_data[31:16]; m_hsw = d_data[15:0]; end
                4'd2:  m_vper = d_data[23:0];
                4'd3:  m_vsw = d_data[23:0];
                4'd4:  begin m_hl = d_data[31:16]; m_hf = d_data[15:0]; end
                4'd5:  m_vst = d_data[23:0];
                4'd6:  m_vend = d_data[23:0];
                4'd7:  begin m_hal = d_data[31:16]; m_haf = d_data[15:0]; m_hae = (d_data != 0); end
                4'd8:  begin m_vae = d_data[31]; m_vaf = d_data[23:0]; end
                4'd9:  m_val = d_data[23:0];
                4'd10: m_bor = d_data[23:0];
                4'd11: begin m_rec = d_data[31]; m_ufc = d_data[23:0]; end
                4'd12: m_skew = d_data[23:0];
                4'd14: m_pol = d_data[2:0];
                default: ;
            endcase
        end
        cyc++;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        d_wr = 1'b1; d_addr = a; d_data = v;
        tick();
        d_wr = 1'b0;
    endtask

    task automatic run_n(input int n);
        repeat (n) tick();
    endtask

    task automatic run_until_f(input int v);
        for (int i = 0; i < 1000; i++) begin
            if (int'(m_f) == v) break;
            tick();
        end
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(ev_mon);
            e = sbq.pop_front();
            chk("hsync R3 R10 R11", 32'(hsync), 32'(e.hs));
            chk("vsync R4 R10", 32'(vsync), 32'(e.vs));
            chk("de R5 R10", 32'(de), 32'(e.de));
            chk("pix_req R6", 32'(pix_req), 32'(e.req));
            chk("rgb_out R7 R8", 32'(rgb_out), 32'(e.rgb));
            chk("underflow R8 R9", 32'(underflow), 32'(e.uf));
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        pix_valid = 1'b0; pix_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_n(2);
        // R1: idle outputs after reset
        chk("R1 hsync", 32'(hsync), 0);
        chk("R1 vsync", 32'(vsync), 0);
        chk("R1 de", 32'(de), 0);
        chk("R1 pix_req", 32'(pix_req), 0);
        chk("R1 rgb_out", 32'(rgb_out), 0);
        chk("R1 underflow", 32'(underflow), 0);

        // 15-clock lines, 8 lines per frame, 120 clocks per frame
        wr(4'd1, (32'd15 << 16) | 32'd2);
        wr(4'd2, 32'd120);
        wr(4'd3, 32'd15);
        wr(4'd4, (32'd12 << 16) | 32'd5);
        wr(4'd5, 32'd45);
        wr(4'd6, 32'd104);
        wr(4'd10, 32'h00FF00);
        wr(4'd11, 32'hFF0000);
        wr(4'd12, 32'd0);
        wr(4'd14, 32'd0);
        wr(4'd0, 32'd1);
        tick();
        chk("R2 still idle after enable write", 32'(hsync), 0);
        tick();
        chk("R2 hsync at frame position 0", 32'(hsync), 1);
        chk("R2 vsync at frame position 0", 32'(vsync), 1);
        run_n(240);

        // R6 inner window: x 7..10, f 60..89
        wr(4'd7, (32'd10 << 16) | 32'd7);
        wr(4'd8, 32'h8000_0000 | 32'd60);
        wr(4'd9, 32'd89);
        run_n(130);
        run_until_f(66);
        tick();
        chk("R7 border left of inner window", 32'(rgb_out), 32'h00FF00);
        tick();
        chk("R6 request at inner window start", 32'(pix_req), 1);

        // R8 underflow without recovery
        drop_f = 67;
        run_until_f(67);
        tick();
        chk("R8 underflow colour on starved cycle", 32'(rgb_out), 32'hFF0000);
        drop_f = -1;
        tick();
        chk("R8 flag set next cycle", 32'(underflow), 1);
        run_n(250);
        chk("R8 flag latched", 32'(underflow), 1);

        // R2 disable clears everything
        wr(4'd0, 32'd0);
        tick();
        chk("R2 flag cleared by disable", 32'(underflow), 0);
        chk("R2 hsync idle when disabled", 32'(hsync), 0);
        wr(4'd0, 32'd1);
        run_n(5);

        // R9 recovery
        wr(4'd11, 32'h80FF0000);
        drop_f = 67;
        run_until_f(67);
        tick();
        drop_f = -1;
        tick();
        chk("R9 flag set before recovery", 32'(underflow), 1);
        run_until_f(0);
        tick();
        chk("R9 flag cleared at frame wrap", 32'(underflow), 0);

        // R10 polarity
        wr(4'd14, 32'd7);
        run_n(130);
        run_until_f(0);
        tick();
        chk("R10 inverted hsync active", 32'(hsync), 0);
        chk("R10 inverted vsync active", 32'(vsync), 0);
        wr(4'd14, 32'd0);

        // R4 skew
        wr(4'd12, 32'd3);
        wr(4'd5, 32'd48);
        wr(4'd6, 32'd107);
        run_n(130);
        run_until_f(2);
        tick();
        chk("R4 vsync before skew", 32'(vsync), 0);
        tick();
        chk("R4 vsync at skew", 32'(vsync), 1);

        // starve and frame wrap in the same cycle: zero porches at the end
        wr(4'd12, 32'd0);
        wr(4'd5, 32'd45);
        wr(4'd4, (32'd14 << 16) | 32'd5);
        wr(4'd6, 32'd119);
        wr(4'd7, 32'd0);
        wr(4'd8, 32'd0);
        run_n(20);
        drop_f = 119;
        run_until_f(119);
        tick();
        tick();
        chk("R8 starve on last frame clock sets flag", 32'(underflow), 1);
        run_until_f(119);
        tick();
        tick();
        chk("R9 recovery wins over starve on wrap", 32'(underflow), 0);
        drop_f = -1;
        run_n(240);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule